// File: doc/BRIEF.md
# Buffered Serial Transmitter with Holding-Empty Interrupt

This block is the transmit half of an asynchronous serial port. A host pushes bytes through a one-cycle write strobe into a queue of sixteen bytes. A separate shift register takes bytes from that queue one at a time. Each byte goes out as a ten-bit frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. One bit moves onto the line for each pulse of an external baud-rate enable. Sending starts as soon as any byte is queued. The queue does not have to fill first.

The host learns when to refill from an 8-bit status word and from an interrupt. The status word has three flags. The holding-empty flag says the queue is empty. The transmitter-empty flag says the queue and the shift register are both empty. The overflow flag is sticky and records a write that was dropped. The holding-empty interrupt follows one of two timing rules:

- If the queue has held two or more bytes at once and has then drained, the interrupt fires immediately. The host can then refill during the character still being shifted.
- After a lone byte, the interrupt waits one full character time. A write during that wait cancels it. This spares the host an interrupt for every single-byte write.

A pending interrupt is cleared by a write or by an interrupt-identification read. An enable input masks the interrupt output.

Top module: `uart_txq_top`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0, and `line_status` reads 8'h60 (bits 5 and 6 set, all other bits 0).
- R2: Each byte is sent as a frame of 0 (start), data bit 0 through data bit 7, and 1 (stop). The line moves to the next bit at each `baud_tick` pulse. `txd` is 1 whenever no frame is in progress.
- R3: Transmission begins with a single queued byte. Up to 16 bytes can be waiting in the queue, and they go out in write order with no idle bit between frames.
- R4: A write to a full queue is discarded and sets `line_status` bit 1. A pulse on `lsr_rd` clears that bit.
- R5: `line_status` bit 5 rises on the clock edge that moves the last queued byte into the shift register. `line_status` bit 6 is 1 only while both the queue and the shift register are empty.
- R6: If the queue occupancy has reached 2 or more since the queue was last empty, the interrupt becomes pending on the same edge as the bit-5 rise in R5.
- R7: Otherwise the interrupt becomes pending on the 10th `baud_tick` edge after that bit-5 rise.
- R8: A write during the R7 wait cancels that wait. The interrupt then waits for the queue to drain again.
- R9: A write or an `iir_rd` pulse clears a pending interrupt by the next edge.
- R10: `irq` equals the pending interrupt ANDed with `irq_en`. A pending interrupt survives while `irq_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| iir_rd | input | 1 | Interrupt identification read; clears pending interrupt |
| lsr_rd | input | 1 | Status read; clears overflow flag |
| irq_en | input | 1 | Holding-empty interrupt enable |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Holding-empty interrupt |
| line_status | output | 8 | Bit 1 overflow, bit 5 holding empty, bit 6 transmitter empty |

## Verification
Several properties are checked on every cycle:
- The line stays high when no frame is active.
- The queue never grows past its depth and is never popped while empty.
- A full write sets the overflow flag.
- A write clears the pending interrupt and cancels the deferral.
- A drain after a multi-byte burst raises the interrupt at once.

Only the bench scenarios can show the rest. The bench compares the bit order and content of each frame against the queued bytes, including which byte is dropped on overflow. It also checks the exact tick on which a deferred interrupt arrives after a lone byte, and shows that a mid-deferral write pushes the interrupt out to the end of the following frame.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
   localparam int STAT_OVF  = 1;
   localparam int STAT_HOLD = 5;
   localparam int STAT_IDLE = 6;
   localparam int STAT_W    = 8;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("txq_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push;

   assign full    = (count == DEPTH[AW:0]);
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (pop)     rptr <= rptr + 1'b1;
         case ({do_push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH[AW:0]);                                    // R3
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);                                           // R3
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         have,
   input  logic [W-1:0] din,
   output logic         take,
   output logic         busy,
   output logic         txd
);
   localparam int FRAME = W + 2;
   localparam int CW    = $clog2(FRAME + 1);

   generate
      if (W < 5) begin : g_bad_width
         $error("txq_shifter: W must be at least 5");
      end
   endgenerate

   logic [FRAME-1:0] sh;
   logic [CW-1:0]    sent;

   assign take = !busy && have;
   assign txd  = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         sent <= '0;
         busy <= 1'b0;
      end else if (take) begin
         sh   <= {1'b1, din, 1'b0};
         sent <= '0;
         busy <= 1'b1;
      end else if (busy && tick) begin
         sh   <= {1'b1, sh[FRAME-1:1]};
         sent <= sent + 1'b1;
         if (sent == CW'(FRAME - 1)) busy <= 1'b0;
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);                                            // R2
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (busy && !txd));                                  // R2
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
   parameter int DEFER_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic drain,
   input  logic multi,
   input  logic wr,
   input  logic fifo_empty,
   input  logic ack,
   output logic pending
);
   localparam int DW = (DEFER_TICKS < 1) ? 1 : $clog2(DEFER_TICKS + 1);

   logic          marker;
   logic          fire;
   logic          deferring;
   logic [DW-1:0] left;

   generate
      if (DEFER_TICKS == 0) begin : g_no_defer
         assign fire      = drain;
         assign deferring = 1'b0;
         assign left      = '0;
      end else begin : g_defer
         logic          dly_q;
         logic [DW-1:0] cnt_q;
         logic          done;
         assign done      = dly_q && tick && (cnt_q == DW'(1)) && !wr;
         assign fire      = (drain && marker) || done;
         assign deferring = dly_q;
         assign left      = cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dly_q <= 1'b0;
               cnt_q <= '0;
            end else if (wr) begin
               dly_q <= 1'b0;
               cnt_q <= '0;
            end else if (drain && !marker) begin
               dly_q <= 1'b1;
               cnt_q <= DW'(DEFER_TICKS);
            end else if (dly_q && tick) begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == DW'(1)) dly_q <= 1'b0;
            end
         end
         AST_DEFER_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
            wr |=> !dly_q);                                      // R8
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         marker  <= 1'b0;
         pending <= 1'b0;
      end else begin
         if (multi)                           marker <= 1'b1;
         else if (fire || (wr && fifo_empty)) marker <= 1'b0;
         if (wr || ack)  pending <= 1'b0;
         else if (fire)  pending <= 1'b1;
      end
   end

   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr || ack) |=> !pending);                                 // R9
   AST_MULTI_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (drain && marker && !ack && !wr) |=> pending);             // R6
   AST_DEFER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      deferring |-> (left != '0));                               // R7
endmodule

// File: rtl/uart_txq_top.sv
module uart_txq_top
   import uart_txq_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int W           = 8,
   parameter int DEFER_TICKS = W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [W-1:0]      wr_data,
   input  logic              iir_rd,
   input  logic              lsr_rd,
   input  logic              irq_en,
   output logic              txd,
   output logic              irq,
   output logic [STAT_W-1:0] line_status
);
   localparam int CNTW = $clog2(DEPTH) + 1;

   logic [W-1:0]    q_dout;
   logic [CNTW-1:0] q_count;
   logic            q_full, q_empty, take, busy, drain, pending, ovf;

   txq_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(take),
      .dout(q_dout), .count(q_count), .full(q_full), .empty(q_empty));

   txq_shifter #(.W(W)) i_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .have(!q_empty),
      .din(q_dout), .take(take), .busy(busy), .txd(txd));

   assign drain = take && (q_count == CNTW'(1)) && !wr_en;

   txq_irq #(.DEFER_TICKS(DEFER_TICKS)) i_irq (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .drain(drain),
      .multi(q_count >= CNTW'(2)), .wr(wr_en), .fifo_empty(q_empty),
      .ack(iir_rd), .pending(pending));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovf <= 1'b0;
      else if (wr_en && q_full)   ovf <= 1'b1;
      else if (lsr_rd)            ovf <= 1'b0;
   end

   always_comb begin
      line_status            = '0;
      line_status[STAT_OVF]  = ovf;
      line_status[STAT_HOLD] = q_empty;
      line_status[STAT_IDLE] = q_empty && !busy;
   end

   assign irq = pending && irq_en;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && q_full) |=> line_status[STAT_OVF]);              // R4
   AST_DRAIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      drain |=> line_status[STAT_HOLD]);                         // R5
endmodule

// File: tb/test_uart_txq_top.sv
module test_uart_txq_top;
   logic       clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0;
   logic [7:0] wr_data = 0;
   logic       iir_rd = 0, lsr_rd = 0, irq_en = 1;
   logic       txd, irq;
   logic [7:0] line_status;
   int checks = 0, errors = 0;
   logic [7:0] expq[$];

   uart_txq_top i_uart_txq_top (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .wr_en(wr_en), .wr_data(wr_data), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
      .irq_en(irq_en), .txd(txd), .irq(irq), .line_status(line_status));

   always #10 clk = ~clk;

   initial begin : tickgen
      forever begin
         repeat (3) @(negedge clk);
         baud_tick = 1;
         @(negedge clk);
         baud_tick = 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input bit kept);
      wr_en = 1; wr_data = b;
      if (kept) expq.push_back(b);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic pulse_iir();
      iir_rd = 1; @(negedge clk); iir_rd = 0;
   endtask

   task automatic wait_idle();
      while (!(line_status[6] && expq.size() == 0)) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // monitor: rebuilds frames at each tick, scoreboard compare (R2, R3)
   initial begin : monitor
      int st = 0;
      logic [7:0] got = 0;
      forever begin
         @(negedge clk);
         if (rst_n && baud_tick) begin
            if (st == 0) begin
               if (!txd) st = 1;
            end else if (st <= 8) begin
               got[st-1] = txd; st++;
            end else begin
               chk("R2 stop bit", txd, 1);
               if (expq.size() == 0) chk("R3 unexpected frame", got, 'hx);
               else chk("R2 R3 frame byte", got, expq.pop_front());
               st = 0;
            end
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 status", line_status, 8'h60);
      chk("R1 txd", txd, 1);
      chk("R1 irq", irq, 0);

      // R7: lone byte, deferred interrupt
      send(8'hA5, 1);
      chk("R5 tx-empty low while busy", line_status[6], 0);
      while (!line_status[5]) @(negedge clk);
      chk("R5 holding empty after load", line_status[5], 1);
      chk("R7 no irq at load", irq, 0);
      n = 0;
      while (n < 10) begin
         if (irq) chk("R7 early irq", irq, 0);
         @(negedge clk);
         if (baud_tick) n++;
      end
      chk("R7 irq before 10th tick edge", irq, 0);
      @(negedge clk);
      chk("R7 irq after 10th tick", irq, 1);
      chk("R5 tx empty at frame end", line_status[6], 1);

      // R10 masking and R9 iir read
      irq_en = 0; @(negedge clk);
      chk("R10 masked", irq, 0);
      irq_en = 1; @(negedge clk);
      chk("R10 kept pending", irq, 1);
      pulse_iir();
      chk("R9 iir read clears", irq, 0);

      // R6: multi-byte burst, immediate interrupt
      send(8'h3C, 1); send(8'h81, 1); send(8'h7E, 1);
      while (!line_status[5]) begin
         if (irq) chk("R6 early irq", irq, 0);
         @(negedge clk);
      end
      chk("R6 irq with holding empty", irq, 1);
      chk("R5 tx not empty yet", line_status[6], 0);
      send(8'h42, 1);
      chk("R9 write clears", irq, 0);
      wait_idle();
      pulse_iir();

      // R8: write during deferral cancels it
      send(8'h11, 1);
      while (!line_status[5]) @(negedge clk);
      n = 0;
      while (n < 4) begin @(negedge clk); if (baud_tick) n++; end
      send(8'hEE, 1);
      while (!line_status[6]) begin
         if (irq) chk("R8 cancelled deferral fired", irq, 0);
         @(negedge clk);
      end
      chk("R8 irq after second frame", irq, 1);
      wait_idle();

      // R4: overflow, 18 writes: one loads, 16 queue, last dropped
      for (int i = 0; i < 18; i++) send(8'(i * 13 + 1), i < 17);
      chk("R4 overflow flag", line_status[1], 1);
      lsr_rd = 1; @(negedge clk); lsr_rd = 0;
      chk("R4 overflow cleared", line_status[1], 0);
      wait_idle();
      repeat (8) @(negedge clk);
      chk("R3 all frames seen", expq.size(), 0);
      finish_run();
   end
endmodule